// File: doc/BRIEF.md
# Return Address Stack Controller

A hardware last-in, first-out store of return addresses for a small processor core. The core's sequencer pushes the current program counter on a call and pops it on a return. An instruction decode strobe can also push and pop. Software can read and rewrite the top entry one byte lane at a time. That lets a program push the current counter and then overwrite it with any return address it chooses.

The stack holds 31 entries of 21 bits each. Pointer value 0 means the stack is empty. Two misuse cases are caught and recorded in sticky flags: pushing onto a full stack, and popping an empty one. When the fault-reset option input is high, the same event also produces a one-cycle reset request for the chip's reset generator. The flags survive an ordinary reset. Only a software clear strobe or the power-on reset clears them.

Occupancy is tracked by a three-state machine. The states are EMPTY (pointer 0), PARTIAL (pointer 1 to 30) and FULL (pointer 31). The transitions are:

- PUSH_FIRST: EMPTY to PARTIAL.
- UNDERFLOW: EMPTY to EMPTY, on a pop.
- PUSH: PARTIAL to PARTIAL.
- PUSH_LAST: PARTIAL to FULL.
- POP: PARTIAL to PARTIAL.
- POP_LAST: PARTIAL to EMPTY.
- OVERFLOW: FULL to FULL, on a push.
- POP_FULL: FULL to PARTIAL.

Top module: `ret_stack_ctrl`

## Requirements
- R1: A push while the pointer is below 31 stores `pc_i` as the new top entry and raises the pointer by one at the same clock edge. The new top is readable combinationally from the next cycle.
- R2: A pop while the pointer is above 0 lowers the pointer by one. The entry pushed before the discarded one becomes readable as the top.
- R3: While the pointer is 0, all three top-of-stack byte outputs read zero.
- R4: A push while the pointer is 31 leaves the pointer and the stored top entry unchanged and sets `full_o`.
- R5: A pop while the pointer is 0 leaves the pointer at 0 and sets `underflow_o`.
- R6: The byte-lane write enables patch the top entry. Bit 0 writes address bits 7:0, bit 1 writes bits 15:8, and bit 2 writes bits 20:16 from data bits 4:0. Lanes that are not enabled are unchanged. `tos_up_o` bits 7:5 always read zero.
- R7: When a push and a pop occur in the same cycle, the push is performed and the pop is ignored. A byte-lane write is ignored in a cycle with a push or pop, and also while the pointer is 0.
- R8: `full_o` and `underflow_o` are sticky. `flag_clr_i` bit 1 clears full and bit 0 clears underflow. `rst_n` leaves both flags unchanged, and `por_n` clears both. A setting event in the same cycle as a clear wins.
- R9: `reset_req_o` is high for exactly the one cycle after an overflow or underflow event, when `fault_rst_en_i` was high at that event. It stays low otherwise.
- R10: `rst_n` or `por_n` low at a clock edge sets the pointer to 0.
- R11: The call/return strobes and the decode-issued push/pop strobes have identical effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low ordinary reset (pointer and request only) |
| por_n | input | 1 | Synchronous active-low power-on reset (everything, including the flags) |
| call_push_i | input | 1 | Push strobe from a call |
| ret_pop_i | input | 1 | Pop strobe from a return |
| op_push_i | input | 1 | Push strobe from instruction decode |
| op_pop_i | input | 1 | Pop strobe from instruction decode |
| pc_i | input | 21 | Program counter value to push |
| tos_we_i | input | 3 | Top-entry byte-lane write enables (bit 0 low, bit 1 high, bit 2 upper) |
| tos_wdata_i | input | 8 | Byte-lane write data |
| flag_clr_i | input | 2 | Flag clear strobes (bit 1 full, bit 0 underflow) |
| fault_rst_en_i | input | 1 | Configuration: request a reset on overflow or underflow |
| sp_o | output | 5 | Current stack pointer |
| tos_lo_o | output | 8 | Top entry bits 7:0 |
| tos_hi_o | output | 8 | Top entry bits 15:8 |
| tos_up_o | output | 8 | Top entry bits 20:16, zero-extended |
| full_o | output | 1 | Sticky overflow flag |
| underflow_o | output | 1 | Sticky underflow flag |
| reset_req_o | output | 1 | One-cycle device reset request |

## Verification
The assertions take the inputs to be clean, synchronous levels at each edge. They also assume `por_n` is applied at start-up before any flag is judged. Any mix of strobes in a cycle is legal, and the properties encode the push-over-pop priority rather than excluding it. The stimulus keeps the two resets synchronous and starts with both low. It then draws strobe mixes from a seeded random source, biased alternately towards pushes and pops, so that both the full and empty boundaries are reached many times.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    // Occupancy of the return stack.
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    // Per-cycle outcome of the pointer machine.
    typedef struct packed {
        logic store;      // write pc into slot indexed by the old pointer
        logic overflow;   // push refused, stack full
        logic underflow;  // pop refused, stack empty
    } ptr_evt_t;

    // Byte lane positions in the top-of-stack write enable.
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;
    localparam int LANE_UP = 2;
    localparam int LANES   = 3;

endpackage

// File: rtl/ret_stack_ptr_fsm.sv
module ret_stack_ptr_fsm
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] sp,
    output ptr_evt_t         evt
);

    localparam logic [PTR_W-1:0] SP_TOP  = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] SP_LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] SP_ONE  = PTR_W'(1);

    occ_state_t       state_q, state_d;
    logic [PTR_W-1:0] sp_q, sp_d;
    logic             run;

    assign run = rst_n & por_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!run) begin
            state_q <= OCC_EMPTY;
            sp_q    <= '0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
        end
    end

    // Next state, next pointer and events.
    always_comb begin
        state_d = state_q;
        sp_d    = sp_q;
        evt     = '0;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) begin                    // PUSH_FIRST
                    evt.store = run;
                    sp_d      = SP_ONE;
                    state_d   = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
                end else if (pop) begin            // UNDERFLOW
                    evt.underflow = run;
                end
            end
            OCC_PARTIAL: begin
                if (push) begin
                    evt.store = run;
                    sp_d      = sp_q + SP_ONE;
                    if (sp_q == SP_LAST) begin     // PUSH_LAST
                        state_d = OCC_FULL;
                    end                            // else PUSH
                end else if (pop) begin
                    sp_d = sp_q - SP_ONE;
                    if (sp_q == SP_ONE) begin      // POP_LAST
                        state_d = OCC_EMPTY;
                    end                            // else POP
                end
            end
            OCC_FULL: begin
                if (push) begin                    // OVERFLOW
                    evt.overflow = run;
                end else if (pop) begin            // POP_FULL
                    sp_d    = SP_LAST;
                    state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                sp_d    = '0;
            end
        endcase
    end

    assign sp = sp_q;

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem
    import ret_stack_pkg::*;
#(
    parameter int DEPTH  = 31,
    parameter int ADDR_W = 21,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              store,
    input  logic              patch,
    input  logic [PTR_W-1:0]  sp,
    input  logic [ADDR_W-1:0] pc,
    input  logic [LANES-1:0]  lane_we,
    input  logic [7:0]        lane_wdata,
    output logic [ADDR_W-1:0] tos
);

    localparam int UP_W = ADDR_W - 16;

    logic [ADDR_W-1:0] slot [DEPTH];

    // Slot g holds entry number g+1. A push writes the slot indexed by the
    // old pointer; a patch edits the slot under the current top.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (store && sp == PTR_W'(g)) begin
                slot[g] <= pc;
            end else if (patch && sp == PTR_W'(g + 1)) begin
                if (lane_we[LANE_LO]) slot[g][7:0]         <= lane_wdata;
                if (lane_we[LANE_HI]) slot[g][15:8]        <= lane_wdata;
                if (lane_we[LANE_UP]) slot[g][ADDR_W-1:16] <= lane_wdata[UP_W-1:0];
            end
        end
    end

    // Combinational top-of-stack read; zero when empty.
    always_comb begin
        tos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == PTR_W'(i + 1)) tos = slot[i];
        end
    end

endmodule

// File: rtl/ret_stack_flags.sv
module ret_stack_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_n,
    input  logic       overflow,
    input  logic       underflow,
    input  logic [1:0] clr,
    input  logic       fault_rst_en,
    output logic       full_flag,
    output logic       unf_flag,
    output logic       reset_req
);

    // Sticky flags: only power-on reset or software clear; set beats clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            full_flag <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            full_flag <= overflow  | (full_flag & ~clr[1]);
            unf_flag  <= underflow | (unf_flag  & ~clr[0]);
        end
    end

    // One-cycle reset request following a fault.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            reset_req <= 1'b0;
        end else begin
            reset_req <= fault_rst_en & (overflow | underflow);
        end
    end

endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter  int DEPTH  = 31,
    parameter  int ADDR_W = 21,
    localparam int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              call_push_i,
    input  logic              ret_pop_i,
    input  logic              op_push_i,
    input  logic              op_pop_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [2:0]        tos_we_i,
    input  logic [7:0]        tos_wdata_i,
    input  logic [1:0]        flag_clr_i,
    input  logic              fault_rst_en_i,
    output logic [PTR_W-1:0]  sp_o,
    output logic [7:0]        tos_lo_o,
    output logic [7:0]        tos_hi_o,
    output logic [7:0]        tos_up_o,
    output logic              full_o,
    output logic              underflow_o,
    output logic              reset_req_o
);

    localparam int UP_W = ADDR_W - 16;

    logic              push, pop, patch;
    ptr_evt_t          evt;
    logic [PTR_W-1:0]  sp;
    logic [ADDR_W-1:0] tos;

    assign push  = call_push_i | op_push_i;
    assign pop   = ret_pop_i | op_pop_i;
    assign patch = (|tos_we_i) & ~push & ~pop & (sp != '0);

    ret_stack_ptr_fsm #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .por_n (por_n),
        .push  (push),
        .pop   (pop),
        .sp    (sp),
        .evt   (evt)
    );

    ret_stack_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
        .clk        (clk),
        .store      (evt.store),
        .patch      (patch),
        .sp         (sp),
        .pc         (pc_i),
        .lane_we    (tos_we_i),
        .lane_wdata (tos_wdata_i),
        .tos        (tos)
    );

    ret_stack_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_n        (por_n),
        .overflow     (evt.overflow),
        .underflow    (evt.underflow),
        .clr          (flag_clr_i),
        .fault_rst_en (fault_rst_en_i),
        .full_flag    (full_o),
        .unf_flag     (underflow_o),
        .reset_req    (reset_req_o)
    );

    assign sp_o     = sp;
    assign tos_lo_o = tos[7:0];
    assign tos_hi_o = tos[15:8];
    assign tos_up_o = 8'(tos[ADDR_W-1:16]);

endmodule

// File: rtl/ret_stack_ctrl_chk.sv
module ret_stack_ctrl_chk #(
    parameter  int DEPTH  = 31,
    parameter  int ADDR_W = 21,
    localparam int PTR_W  = $clog2(DEPTH + 1),
    localparam int UP_W   = ADDR_W - 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              call_push_i,
    input logic              ret_pop_i,
    input logic              op_push_i,
    input logic              op_pop_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [1:0]        flag_clr_i,
    input logic              fault_rst_en_i,
    input logic [PTR_W-1:0]  sp_o,
    input logic [7:0]        tos_lo_o,
    input logic [7:0]        tos_hi_o,
    input logic [7:0]        tos_up_o,
    input logic              full_o,
    input logic              underflow_o,
    input logic              reset_req_o
);

    logic              push_w, pop_w;
    logic [ADDR_W-1:0] tos_w;

    assign push_w = call_push_i | op_push_i;
    assign pop_w  = ret_pop_i | op_pop_i;
    assign tos_w  = {tos_up_o[UP_W-1:0], tos_hi_o, tos_lo_o};

    a_r1_push_inc: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (push_w && sp_o < PTR_W'(DEPTH)) |=>
        (sp_o == PTR_W'($past(sp_o) + 1'b1) && tos_w == $past(pc_i)));

    a_r2_pop_dec: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!push_w && pop_w && sp_o != '0) |=> (sp_o == PTR_W'($past(sp_o) - 1'b1)));

    a_r3_empty_zero: assert property (@(posedge clk)
        (sp_o == '0) |-> (tos_lo_o == 8'd0 && tos_hi_o == 8'd0 && tos_up_o == 8'd0));

    a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (push_w && sp_o == PTR_W'(DEPTH)) |=>
        (sp_o == PTR_W'(DEPTH) && full_o && $stable(tos_w)));

    a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!push_w && pop_w && sp_o == '0) |=> (sp_o == '0 && underflow_o));

    a_r6_up_zero: assert property (@(posedge clk)
        ((tos_up_o >> UP_W) == 8'd0));

    a_r8_full_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (full_o && !flag_clr_i[1]) |=> full_o);

    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (underflow_o && !flag_clr_i[0]) |=> underflow_o);

    a_r9_req_on: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (fault_rst_en_i && ((push_w && sp_o == PTR_W'(DEPTH)) ||
                            (!push_w && pop_w && sp_o == '0))) |=> reset_req_o);

    a_r9_req_off: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (!fault_rst_en_i) |=> !reset_req_o);

    a_r10_reset_ptr: assert property (@(posedge clk)
        (!rst_n || !por_n) |=> (sp_o == '0));

endmodule

bind ret_stack_ctrl ret_stack_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_n          (por_n),
    .call_push_i    (call_push_i),
    .ret_pop_i      (ret_pop_i),
    .op_push_i      (op_push_i),
    .op_pop_i       (op_pop_i),
    .pc_i           (pc_i),
    .flag_clr_i     (flag_clr_i),
    .fault_rst_en_i (fault_rst_en_i),
    .sp_o           (sp_o),
    .tos_lo_o       (tos_lo_o),
    .tos_hi_o       (tos_hi_o),
    .tos_up_o       (tos_up_o),
    .full_o         (full_o),
    .underflow_o    (underflow_o),
    .reset_req_o    (reset_req_o)
);

// File: tb/ret_stack_ctrl_tb.sv
module ret_stack_ctrl_tb;

    localparam int CLK_P  = 10;
    localparam int DEPTH  = 31;
    localparam int ADDR_W = 21;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0, por_n = 1'b0;
    logic              call_push = 1'b0, ret_pop = 1'b0, op_push = 1'b0, op_pop = 1'b0;
    logic [ADDR_W-1:0] pc = '0;
    logic [2:0]        tos_we = '0;
    logic [7:0]        tos_wd = '0;
    logic [1:0]        fclr = '0;
    logic              fen = 1'b0;
    logic [4:0]        sp_o;
    logic [7:0]        tlo, thi, tup;
    logic              full_o, unf_o, req_o;

    ret_stack_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .call_push_i(call_push), .ret_pop_i(ret_pop), .op_push_i(op_push), .op_pop_i(op_pop),
        .pc_i(pc), .tos_we_i(tos_we), .tos_wdata_i(tos_wd), .flag_clr_i(fclr),
        .fault_rst_en_i(fen), .sp_o(sp_o), .tos_lo_o(tlo), .tos_hi_o(thi), .tos_up_o(tup),
        .full_o(full_o), .underflow_o(unf_o), .reset_req_o(req_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    // Reference model state.
    logic [ADDR_W-1:0] m_mem [DEPTH];
    int                m_sp = 0;
    logic              m_full = 1'b0, m_unf = 1'b0, m_req = 1'b0;
    int                n_chk = 0, n_err = 0;
    bit                done = 1'b0;
    string             tag = "R10";

    function automatic logic [ADDR_W-1:0] exp_tos();
        return (m_sp == 0) ? '0 : m_mem[m_sp - 1];
    endfunction

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model update from the inputs present at the last edge.
    task automatic model_edge();
        logic ps, pp, ov, un;
        ps = call_push | op_push;
        pp = ret_pop | op_pop;
        ov = 1'b0; un = 1'b0;
        if (!por_n) begin
            m_sp = 0; m_full = 0; m_unf = 0; m_req = 0;
        end else if (!rst_n) begin
            m_sp = 0; m_req = 0;
        end else begin
            if (ps) begin
                if (m_sp == DEPTH) ov = 1'b1;
                else begin m_mem[m_sp] = pc; m_sp++; end
            end else if (pp) begin
                if (m_sp == 0) un = 1'b1;
                else m_sp--;
            end else if (tos_we != 0 && m_sp != 0) begin
                if (tos_we[0]) m_mem[m_sp-1][7:0]   = tos_wd;
                if (tos_we[1]) m_mem[m_sp-1][15:8]  = tos_wd;
                if (tos_we[2]) m_mem[m_sp-1][20:16] = tos_wd[4:0];
            end
            m_full = ov | (m_full & ~fclr[1]);
            m_unf  = un | (m_unf & ~fclr[0]);
            m_req  = fen & (ov | un);
        end
    endtask

    task automatic step();
        logic [ADDR_W-1:0] e;
        @(posedge clk);
        #1;
        model_edge();
        e = exp_tos();
        chk("sp", sp_o, m_sp);
        chk("tos_lo", tlo, e[7:0]);
        chk("tos_hi", thi, e[15:8]);
        chk("tos_up", tup, {3'b0, e[20:16]});
        chk("full", full_o, m_full);
        chk("underflow", unf_o, m_unf);
        chk("reset_req", req_o, m_req);
        call_push = 0; ret_pop = 0; op_push = 0; op_pop = 0;
        tos_we = '0; fclr = '0;
    endtask

    task automatic do_push(logic [ADDR_W-1:0] v, bit via_op);
        pc = v;
        if (via_op) op_push = 1'b1; else call_push = 1'b1;
        step();
    endtask

    task automatic do_pop(bit via_op);
        if (via_op) op_pop = 1'b1; else ret_pop = 1'b1;
        step();
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

        // Reset state.
        tag = "R10"; step(); step();
        por_n = 1'b1; rst_n = 1'b1;
        tag = "R3"; step();

        // Pushes through both port pairs.
        tag = "R1";  do_push(21'h1ABCDE, 0); do_push(21'h012345, 0);
        tag = "R11"; do_push(21'h0F0F0F, 1);
        tag = "R2";  do_pop(0);
        tag = "R11"; do_pop(1);

        // Byte lane patching, upper lane drops data bits 7:5.
        tag = "R6";
        tos_we = 3'b001; tos_wd = 8'h5A; step();
        tos_we = 3'b100; tos_wd = 8'hFF; step();
        tos_we = 3'b010; tos_wd = 8'h00; step();

        // Priorities and ignored writes.
        tag = "R7";
        call_push = 1; op_pop = 1; pc = 21'h111111; step();
        ret_pop = 1; tos_we = 3'b111; tos_wd = 8'hEE; step();
        do_pop(0);
        tos_we = 3'b111; tos_wd = 8'h77; step();

        // Underflow with reset request, request lasts one cycle.
        fen = 1'b1;
        tag = "R5"; do_pop(1);
        tag = "R9"; step();
        tag = "R3"; step();

        // Fill to the top, then overflow with the request disabled.
        fen = 1'b0;
        tag = "R1";
        for (int i = 0; i < DEPTH; i++) do_push(ADDR_W'(32'h100 * i + 7), i[0]);
        tag = "R4"; do_push(21'h1FFFFF, 0);
        tag = "R9"; step();

        // Ordinary reset keeps the flags.
        tag = "R8"; rst_n = 1'b0; step(); rst_n = 1'b1; step();
        tag = "R10"; step();

        // Clears: full only, then a set coinciding with a clear.
        tag = "R8"; fclr = 2'b10; step();
        fclr = 2'b01; ret_pop = 1; step();
        fclr = 2'b01; step();
        tag = "R5"; do_pop(0);
        tag = "R8"; por_n = 1'b0; step(); por_n = 1'b1; step();

        // Seeded random traffic.
        for (int i = 0; i < 6000; i++) begin
            int r;
            bit push_bias;
            push_bias = ((i / 300) % 2) == 0;
            r = int'($urandom % 20);
            pc = ADDR_W'($urandom);
            fen = ($urandom % 4) == 0;
            if ((push_bias && r < 9) || (!push_bias && r < 3)) begin
                tag = "R1"; if (r[0]) op_push = 1; else call_push = 1;
            end else if (r < 13) begin
                tag = "R2"; if (r[0]) op_pop = 1; else ret_pop = 1;
            end else if (r < 16) begin
                tag = "R6"; tos_we = 3'($urandom); tos_wd = 8'($urandom);
            end else if (r < 17) begin
                tag = "R8"; fclr = 2'($urandom);
            end else if (r < 18) begin
                tag = "R7"; op_push = 1; ret_pop = 1; tos_we = 3'b111;
            end else begin
                tag = "R11";
            end
            if (($urandom % 500) == 0) begin tag = "R10"; rst_n = 1'b0; end
            step();
            rst_n = 1'b1;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule